// File: doc/BRIEF.md
# CAN bit timing unit

This block divides each CAN bit into its timing segments. A programmable prescaler turns the system clock into time-quantum ticks. A segment sequencer walks each bit through three segments: a one-quantum synchronization segment, a first time segment that covers propagation and phase-1 time, and a second time segment for phase-2 time. The block samples the receive line where the first time segment meets the second. It marks that point and the start of every bit with single-cycle strobes, which a frame engine uses to shift bits in and out.

The block keeps its bit clock aligned to other nodes in two ways. When the frame logic reports an idle bus, a dominant-going edge restarts the bit at once, and no limit applies. During a frame, a dominant-going edge that arrives late stretches the first time segment. An edge that arrives early trims the second time segment. Either correction is limited to a programmable jump width, and only one correction is made per bit. If the configuration fields break any range or ordering rule, the block holds its timing logic cleared and raises an error flag.

Top module: `canbt_timing`

## Requirements
- R1: `tq_stb_o` is high for one cycle in every `presc_i`+1 clock cycles. It is high in the first cycle after reset is released and in the first cycle after the configuration becomes legal.
- R2: `seg_o` shows the current segment: 2'b00 is synchronization (1 quantum), 2'b01 is time segment 1 (`seg1_i`+1 quanta plus any lengthening), and 2'b10 is time segment 2 (`seg2_i`+1 quanta minus any shortening). The segment lengths are taken when the synchronization segment ends.
- R3: `sample_stb_o` is high in the cycle of the tick that ends time segment 1. At the following edge, `sample_bit_o` captures `rx_i`.
- R4: `bit_start_o` is high in the cycle of the tick that ends time segment 2. The next segment is synchronization.
- R5: A falling `rx_i` edge (1 to 0, where 0 is dominant) seen while `bus_idle_i` is 0 and the block is in time segment 1 at quantum index q (counted from 0) lengthens that segment by min(q+1, `jump_i`+1) quanta.
- R6: The same kind of edge in time segment 2 at quantum index q shortens that segment by min(L2-q-1, `jump_i`+1), where L2 is its current length. The quantum that holds the edge is never removed.
- R7: An edge in the synchronization segment, any rising edge, and any edge after the first correction of a bit leave the bit timing unchanged. The first eligible edge of a bit uses up that bit's correction even if the adjustment is zero.
- R8: A falling edge while `bus_idle_i` is 1 forces the synchronization segment on the next cycle and restarts the prescaler, so the next tick comes `presc_i`+1 cycles later. No sample or bit-start strobe is given in that cycle, and no correction is made until the next bit starts.
- R9: `cfg_err_o` is 1 when any of these holds: `seg1_i` < 3, `seg2_i` < 1, `seg1_i` <= `seg2_i`, `seg2_i` < `jump_i`, or a total bit of `seg1_i`+`seg2_i`+3 quanta lies outside 8..25. While it is 1, no tick, sample or bit-start strobe appears, and the segment returns to 2'b00.
- R10: During reset, `seg_o` is 2'b00, both the sample and bit-start strobes are low, and `sample_bit_o` is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously |
| rx_i | input | 1 | Received bus level, 0 = dominant |
| bus_idle_i | input | 1 | High while the frame logic sees an idle bus |
| presc_i | input | 6 | Prescaler; a quantum lasts this value + 1 clocks |
| seg1_i | input | 4 | Time segment 1 setting, length = value + 1 |
| seg2_i | input | 3 | Time segment 2 setting, length = value + 1 |
| jump_i | input | 2 | Jump width setting, width = value + 1 |
| tq_stb_o | output | 1 | Time-quantum tick |
| sample_stb_o | output | 1 | Sample-point strobe |
| sample_bit_o | output | 1 | Bus level captured at the last sample point |
| bit_start_o | output | 1 | End of time segment 2, a new bit begins |
| seg_o | output | 2 | Current segment code |
| cfg_err_o | output | 1 | Configuration rule violated |

## Verification
Random legal configurations run under random bus toggling and idle windows. A reference model in the bench predicts every strobe, the segment code and the sampled bit on each cycle, so the tests catch errors in the prescaler, in segment lengths and in how corrections interact with hard synchronization. Directed single edges placed at chosen quantum positions of a bit separate lengthening, shortening, clipping to the jump width, the no-effect case in the synchronization segment and the one-correction rule, each judged by the measured bit length. Separate tests cover the error flag: one runs each broken rule on its own and another runs the legal boundary configurations. Another test checks the tick spacing with a non-zero prescaler.

// File: rtl/canbt_pkg.sv
package canbt_pkg;
  typedef enum logic [1:0] {
    SEG_SYNC = 2'b00,
    SEG_TS1  = 2'b01,
    SEG_TS2  = 2'b10
  } seg_e;
endpackage

// File: rtl/canbt_cfg_chk.sv
module canbt_cfg_chk #(
  parameter int TS1_W   = 4,
  parameter int TS2_W   = 3,
  parameter int SJW_W   = 2,
  parameter int TS1_MIN = 3,
  parameter int TS2_MIN = 1,
  parameter int BIT_MIN = 8,
  parameter int BIT_MAX = 25
) (
  input  logic [TS1_W-1:0] seg1,
  input  logic [TS2_W-1:0] seg2,
  input  logic [SJW_W-1:0] jump,
  output logic             cfg_err
);
  localparam int TOT_W = TS1_W + 2;

  logic [TOT_W-1:0] tot;

  always_comb begin
    tot = TOT_W'(seg1) + TOT_W'(seg2) + TOT_W'(3);
    cfg_err = (seg1 < TS1_W'(TS1_MIN))
            | (seg2 < TS2_W'(TS2_MIN))
            | (TOT_W'(seg1) <= TOT_W'(seg2))
            | (TOT_W'(seg2) < TOT_W'(jump))
            | (tot < TOT_W'(BIT_MIN))
            | (tot > TOT_W'(BIT_MAX));
  end
endmodule

// File: rtl/canbt_tq_div.sv
module canbt_tq_div #(
  parameter int BRP_W = 6
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             hold,
  input  logic             restart,
  input  logic [BRP_W-1:0] brp,
  output logic             tq_stb
);
  logic [BRP_W-1:0] div_q, div_n;

  always_comb begin
    tq_stb = (div_q == '0) & ~hold;
    if (hold)              div_n = '0;
    else if (restart)      div_n = brp;
    else if (div_q == '0)  div_n = brp;
    else                   div_n = div_q - BRP_W'(1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) div_q <= '0;
    else        div_q <= div_n;
  end

  // R1
  tq_gap_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (tq_stb && brp != '0 && !restart && !hold) |=> !tq_stb);
endmodule

// File: rtl/canbt_seg_ctrl.sv
module canbt_seg_ctrl
  import canbt_pkg::*;
#(
  parameter int TS1_W = 4,
  parameter int TS2_W = 3,
  parameter int SJW_W = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             hold,
  input  logic             tq_stb,
  input  logic             rx_in,
  input  logic             bus_idle,
  input  logic [TS1_W-1:0] seg1,
  input  logic [TS2_W-1:0] seg2,
  input  logic [SJW_W-1:0] jump,
  output seg_e             seg_o,
  output logic             sample_stb,
  output logic             bit_start,
  output logic             sample_bit,
  output logic             hsync
);
  localparam int CNT_W = TS1_W + 2;
  localparam int L2_W  = TS2_W + 1;

  seg_e             seg_q, seg_n;
  logic [CNT_W-1:0] qcnt_q, qcnt_n, len1_q, len1_n, len1_adj;
  logic [L2_W-1:0]  len2_q, len2_n, len2_adj;
  logic             done_q, done_n, rxp_q, sbit_q, sbit_n;
  logic             fall, rs_ok, ts1_end, ts2_end;
  logic [CNT_W-1:0] sj_eff, late, room, step1, step2;

  always_comb begin
    fall   = rxp_q & ~rx_in;
    hsync  = fall & bus_idle & ~hold;
    rs_ok  = fall & ~bus_idle & ~done_q & (seg_q != SEG_SYNC);
    sj_eff = CNT_W'(jump) + CNT_W'(1);
    late   = qcnt_q + CNT_W'(1);
    room   = CNT_W'(len2_q) - qcnt_q - CNT_W'(1);
    step1  = (late < sj_eff) ? late : sj_eff;
    step2  = (room < sj_eff) ? room : sj_eff;
    len1_adj = len1_q + ((rs_ok && seg_q == SEG_TS1) ? step1 : '0);
    len2_adj = len2_q - ((rs_ok && seg_q == SEG_TS2) ? L2_W'(step2) : '0);
    ts1_end  = (seg_q == SEG_TS1) && (late == len1_adj);
    ts2_end  = (seg_q == SEG_TS2) && (late == CNT_W'(len2_adj));
    sample_stb = tq_stb & ts1_end & ~hsync & ~hold;
    bit_start  = tq_stb & ts2_end & ~hsync & ~hold;
    sbit_n = sample_stb ? rx_in : sbit_q;

    seg_n  = seg_q;
    qcnt_n = qcnt_q;
    len1_n = len1_adj;
    len2_n = len2_adj;
    done_n = done_q | rs_ok;
    if (hold) begin
      seg_n = SEG_SYNC; qcnt_n = '0; done_n = 1'b0;
    end else if (hsync) begin
      seg_n = SEG_SYNC; qcnt_n = '0; done_n = 1'b1;
    end else if (tq_stb) begin
      case (seg_q)
        SEG_SYNC: begin
          seg_n  = SEG_TS1;
          qcnt_n = '0;
          len1_n = CNT_W'(seg1) + CNT_W'(1);
          len2_n = L2_W'(seg2) + L2_W'(1);
        end
        SEG_TS1: begin
          if (ts1_end) begin seg_n = SEG_TS2; qcnt_n = '0; end
          else         qcnt_n = late;
        end
        default: begin
          if (ts2_end) begin seg_n = SEG_SYNC; qcnt_n = '0; done_n = 1'b0; end
          else         qcnt_n = late;
        end
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      seg_q  <= SEG_SYNC;
      qcnt_q <= '0;
      len1_q <= '0;
      len2_q <= '0;
      done_q <= 1'b0;
      rxp_q  <= 1'b1;
      sbit_q <= 1'b1;
    end else begin
      seg_q  <= seg_n;
      qcnt_q <= qcnt_n;
      len1_q <= len1_n;
      len2_q <= len2_n;
      done_q <= done_n;
      rxp_q  <= rx_in;
      sbit_q <= sbit_n;
    end
  end

  assign seg_o      = seg_q;
  assign sample_bit = sbit_q;

  // R2
  ts1_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (seg_q == SEG_TS1) |-> (qcnt_q < len1_q));
  // R6
  ts2_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (seg_q == SEG_TS2) |-> (qcnt_q < CNT_W'(len2_q)));
  // R3
  sample_to_ts2_chk: assert property (@(posedge clk) disable iff (!rst_n)
    sample_stb |=> (seg_q == SEG_TS2));
  // R4
  bit_start_to_sync_chk: assert property (@(posedge clk) disable iff (!rst_n)
    bit_start |=> (seg_q == SEG_SYNC));
  // R7
  single_resync_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (seg_q == SEG_TS2 && done_q && !hold && !hsync) |=> $stable(len2_q));
  // R8
  hard_sync_chk: assert property (@(posedge clk) disable iff (!rst_n)
    hsync |=> (seg_q == SEG_SYNC && qcnt_q == '0 && done_q));
endmodule

// File: rtl/canbt_timing.sv
module canbt_timing #(
  parameter int BRP_W   = 6,
  parameter int TS1_W   = 4,
  parameter int TS2_W   = 3,
  parameter int SJW_W   = 2,
  parameter int TS1_MIN = 3,
  parameter int TS2_MIN = 1,
  parameter int BIT_MIN = 8,
  parameter int BIT_MAX = 25
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             rx_i,
  input  logic             bus_idle_i,
  input  logic [BRP_W-1:0] presc_i,
  input  logic [TS1_W-1:0] seg1_i,
  input  logic [TS2_W-1:0] seg2_i,
  input  logic [SJW_W-1:0] jump_i,
  output logic             tq_stb_o,
  output logic             sample_stb_o,
  output logic             sample_bit_o,
  output logic             bit_start_o,
  output logic [1:0]       seg_o,
  output logic             cfg_err_o
);
  import canbt_pkg::*;

  logic cfg_err_w, tq_w, hsync_w;
  seg_e seg_w;

  canbt_cfg_chk #(
    .TS1_W(TS1_W), .TS2_W(TS2_W), .SJW_W(SJW_W),
    .TS1_MIN(TS1_MIN), .TS2_MIN(TS2_MIN), .BIT_MIN(BIT_MIN), .BIT_MAX(BIT_MAX)
  ) u_cfg (
    .seg1(seg1_i), .seg2(seg2_i), .jump(jump_i), .cfg_err(cfg_err_w)
  );

  canbt_tq_div #(.BRP_W(BRP_W)) u_div (
    .clk(clk), .rst_n(rst_n), .hold(cfg_err_w), .restart(hsync_w),
    .brp(presc_i), .tq_stb(tq_w)
  );

  canbt_seg_ctrl #(.TS1_W(TS1_W), .TS2_W(TS2_W), .SJW_W(SJW_W)) u_seg (
    .clk(clk), .rst_n(rst_n), .hold(cfg_err_w), .tq_stb(tq_w),
    .rx_in(rx_i), .bus_idle(bus_idle_i), .seg1(seg1_i), .seg2(seg2_i),
    .jump(jump_i), .seg_o(seg_w), .sample_stb(sample_stb_o),
    .bit_start(bit_start_o), .sample_bit(sample_bit_o), .hsync(hsync_w)
  );

  assign tq_stb_o  = tq_w;
  assign seg_o     = seg_w;
  assign cfg_err_o = cfg_err_w;

  // R9
  err_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_err_w |=> (seg_o == 2'b00));
endmodule

// File: tb/canbt_timing_tb_top.sv
`timescale 1ns/1ps
module canbt_timing_tb_top;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic rx = 1'b1, idle = 1'b0;
  logic [5:0] brp = '0;
  logic [3:0] t1 = 4'd7;
  logic [2:0] t2 = 3'd3;
  logic [1:0] sj = 2'd1;
  logic tq, samp, sbit, bst, err;
  logic [1:0] seg;

  int p_brp = 0, p_t1 = 7, p_t2 = 3, p_sj = 1;
  int total = 0, bad = 0;
  bit finished = 0;

  int m_fresh, m_div, m_pos, m_len1, m_len2, m_done, m_sbit, m_rxp;
  string m_ctx;

  always #10 clk = ~clk;

  canbt_timing dut_i (
    .clk(clk), .rst_n(rst_n), .rx_i(rx), .bus_idle_i(idle),
    .presc_i(brp), .seg1_i(t1), .seg2_i(t2), .jump_i(sj),
    .tq_stb_o(tq), .sample_stb_o(samp), .sample_bit_o(sbit),
    .bit_start_o(bst), .seg_o(seg), .cfg_err_o(err)
  );

  function automatic int imin(int a, int b);
    return (a < b) ? a : b;
  endfunction

  function automatic bit cfg_ok(int a1, int a2, int s);
    return a1 >= 3 && a2 >= 1 && a1 > a2 && a2 >= s &&
           (a1 + a2 + 3) >= 8 && (a1 + a2 + 3) <= 25;
  endfunction

  // bit length in quanta after one falling edge in quantum k of the bit
  function automatic int exp_len(int a1, int a2, int s, int k);
    int l1, l0;
    l1 = a1 + 1;
    l0 = 1 + l1 + a2 + 1;
    if (k == 0)       return l0;
    else if (k <= l1) return l0 + imin(k, s + 1);
    else              return l0 - imin(l0 - 1 - k, s + 1);
  endfunction

  task automatic chk(string tag, int act, int exp, string what);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s %s actual=%0d expected=%0d at %0t", tag, what, act, exp, $time);
    end
  endtask

  task automatic model_reset();
    m_fresh = 1; m_div = 0; m_pos = 0; m_len1 = 0; m_len2 = 0;
    m_done = 0; m_sbit = 1; m_rxp = 1; m_ctx = "";
  endtask

  task automatic model_step();
    bit e, tick, fall, hs, sp, en;
    int segx, rem;
    e    = !cfg_ok(t1, t2, sj);
    tick = !e && (m_fresh != 0 || m_div == int'(brp));
    fall = (m_rxp == 1) && !rx;
    hs   = fall && idle && !e;
    segx = (m_pos == 0) ? 0 : ((m_pos <= m_len1) ? 1 : 2);
    if (!e && fall && !idle && m_done == 0 && m_pos != 0) begin
      if (segx == 1) begin
        m_len1 += imin(m_pos, int'(sj) + 1); m_ctx = "R5";
      end else begin
        rem = m_len1 + m_len2 - m_pos;
        m_len2 -= imin(rem, int'(sj) + 1); m_ctx = "R6";
      end
      m_done = 1;
    end
    sp = tick && !hs && segx == 1 && m_pos == m_len1;
    en = tick && !hs && segx == 2 && m_pos == m_len1 + m_len2;
    chk("R1", int'(tq), int'(tick), "tq strobe");
    chk((m_ctx == "") ? "R2" : m_ctx, int'(seg), segx, "segment");
    chk((m_ctx == "") ? "R3" : m_ctx, int'(samp), int'(sp), "sample strobe");
    chk("R3", int'(sbit), m_sbit, "sampled bit");
    chk((m_ctx == "") ? "R4" : m_ctx, int'(bst), int'(en), "bit start");
    chk("R9", int'(err), int'(e), "config error");
    if (e) begin
      m_fresh = 1; m_pos = 0; m_done = 0; m_ctx = "";
    end else if (hs) begin
      m_fresh = 0; m_div = 0; m_pos = 0; m_done = 1; m_ctx = "R8";
    end else begin
      if (tick) begin m_fresh = 0; m_div = 0; end
      else m_div++;
      if (tick) begin
        if (m_pos == 0) begin
          m_len1 = int'(t1) + 1; m_len2 = int'(t2) + 1; m_pos = 1;
        end else if (en) begin
          m_pos = 0; m_done = 0; m_ctx = "";
        end else m_pos++;
      end
    end
    if (sp) m_sbit = int'(rx);
    m_rxp = int'(rx);
  endtask

  task automatic apply_cfg();
    brp = 6'(p_brp); t1 = 4'(p_t1); t2 = 3'(p_t2); sj = 2'(p_sj);
  endtask

  task automatic cyc(input bit rv, input bit iv);
    @(posedge clk); #2;
    rx = rv; idle = iv; apply_cfg();
    #10;
    model_step();
  endtask

  task automatic do_reset();
    @(posedge clk); #2;
    rst_n = 1'b0; rx = 1'b1; idle = 1'b0; apply_cfg();
    model_reset();
    #10;
    chk("R10", int'(seg), 0, "reset segment");
    chk("R10", int'(samp), 0, "reset sample strobe");
    chk("R10", int'(bst), 0, "reset bit start");
    chk("R10", int'(sbit), 1, "reset sampled bit");
    @(posedge clk);
    @(posedge clk); #2;
    rst_n = 1'b1;
    #10;
    model_step();
  endtask

  task automatic wait_bit();
    for (int i = 0; i < 3000; i++) begin
      cyc(1'b1, 1'b0);
      if (bst) break;
    end
  endtask

  // one or two falling edges at quantum positions k and k2 (k2 < 0: none)
  task automatic meas(int k, int k2, string tag);
    int len;
    len = -1;
    wait_bit();
    for (int j = 1; j < 100; j++) begin
      cyc((j == k + 1 || j == k2 + 1) ? 1'b0 : 1'b1, 1'b0);
      if (bst) begin len = j; break; end
    end
    chk(tag, len, exp_len(p_t1, p_t2, p_sj, k), "bit length");
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      total++; bad++;
      $display("FAIL R1 watchdog expired actual=0 expected=1");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    int cnt, len;
    bit rv, iv;
    void'($urandom(32'd4242));

    // R10 reset state, then R5/R6/R7 single edges (brp 0, 13-quantum bit)
    p_brp = 0; p_t1 = 7; p_t2 = 3; p_sj = 1;
    do_reset();
    meas(0, -1, "R7");
    meas(1, -1, "R5");
    meas(5, -1, "R5");
    meas(9, -1, "R6");
    meas(11, -1, "R6");
    meas(12, -1, "R6");
    meas(3, 10, "R7");

    // R8 hard sync mid-bit, then a clean bit of the base length
    wait_bit();
    for (int j = 1; j <= 5; j++) cyc(1'b1, 1'b0);
    cyc(1'b0, 1'b1);
    len = -1;
    for (int j = 1; j < 100; j++) begin
      cyc(1'b1, 1'b0);
      if (bst) begin len = j; break; end
    end
    chk("R8", len, 13, "bit length after hard sync");

    // R1 tick spacing with prescaler 4
    p_brp = 4;
    do_reset();
    cnt = 0;
    for (int j = 0; j < 50; j++) begin cyc(1'b1, 1'b0); if (tq) cnt++; end
    chk("R1", cnt, 10, "ticks in 50 cycles");

    // R9 each broken rule, then legal boundaries without reset
    for (int c = 0; c < 5; c++) begin
      case (c)
        0: begin p_t1 = 2;  p_t2 = 1; p_sj = 0; end
        1: begin p_t1 = 7;  p_t2 = 0; p_sj = 0; end
        2: begin p_t1 = 4;  p_t2 = 4; p_sj = 0; end
        3: begin p_t1 = 7;  p_t2 = 1; p_sj = 2; end
        default: begin p_t1 = 3; p_t2 = 1; p_sj = 0; end
      endcase
      p_brp = 1;
      do_reset();
      cnt = 0;
      for (int j = 0; j < 20; j++) begin cyc(1'b1, 1'b0); if (tq || samp || bst) cnt++; end
      chk("R9", cnt, 0, "strobes under bad config");
      chk("R9", int'(err), 1, "error flag");
    end
    p_t1 = 3; p_t2 = 2; p_sj = 2; p_brp = 0;
    for (int j = 0; j < 60; j++) cyc(1'b1, 1'b0);
    chk("R9", int'(err), 0, "8-quantum boundary legal");
    p_t1 = 15; p_t2 = 7; p_sj = 3;
    for (int j = 0; j < 80; j++) cyc(1'b1, 1'b0);
    chk("R9", int'(err), 0, "25-quantum boundary legal");

    // random legal configurations with random bus activity
    for (int n = 0; n < 30; n++) begin
      do begin
        p_t1 = $urandom_range(3, 15); p_t2 = $urandom_range(1, 7);
        p_sj = $urandom_range(0, 3);
      end while (!cfg_ok(p_t1, p_t2, p_sj));
      p_brp = $urandom_range(0, 5);
      do_reset();
      rv = 1'b1; iv = 1'b0;
      for (int j = 0; j < 500; j++) begin
        if ($urandom_range(0, 99) == 0) iv = ~iv;
        if ($urandom_range(0, 11) == 0) rv = ~rv;
        cyc(rv, iv);
      end
    end

    finished = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule